// File: doc/BRIEF.md
# Receive FIFO Threshold and Idle Ready Controller

This block controls the receive side of a byte FIFO in a serial receiver. It stores the bytes that the deserialiser delivers, reports how many bytes are waiting, and returns them in arrival order when the bus reads. It raises a ready flag when the number of stored bytes reaches a threshold that software programs. A partly filled FIFO must not hold its bytes back forever, so an idle timer also raises the flag. The timer runs on baud ticks and fires after a fixed number of ticks with no byte received and no byte read.

A receive error switches the FIFO off. The enable cannot be set again while the error input stays high. While the FIFO is off, its contents and count are kept, incoming bytes and reads are ignored, and the idle timer is held at zero. A flush empties the FIFO and clears the overrun flag. A byte that arrives when the FIFO is full is dropped and sets the overrun flag.

Top module: `rxq_ready_ctl`

## Requirements
- R1: After reset, count is 0, ready, overrun and fifo_en are 0, and the threshold is 8.
- R2: While fifo_en is 1, an accepted rx_strobe adds one to count, and an rd_strobe with count above 0 removes one. The cycle after a read, rd_data holds the oldest stored byte (first in, first out). All outputs change on the clock edge that samples the stimulus.
- R3: ready is 1 whenever count is greater than or equal to the threshold. A thr_wr strobe loads thr_wdata as the new threshold.
- R4: With fifo_en and idle_en both 1 and 0 < count < threshold, ready rises on the 8th baud_tick counted with no accepted byte and no accepted read. It does not rise on an earlier tick.
- R5: An accepted read or an accepted byte restarts the idle count from zero, and any idle-raised ready drops.
- R6: Clearing fifo_en resets the idle count. After fifo_en is set again with data still stored, 8 fresh ticks are needed before ready rises.
- R7: rx_err high clears fifo_en on the next edge. An enable write (en_wr with en_val 1) is ignored while rx_err is high.
- R8: While fifo_en is 0, rx_strobe and rd_strobe have no effect, and count and the stored bytes are kept.
- R9: flush sets count to 0 and clears overrun and ready.
- R10: The FIFO holds 16 bytes. A byte received while count is 16 is dropped, count stays 16, and overrun is set. overrun stays set until a flush.
- R11: ready falls once count is below the threshold and no idle timeout is pending.
- R12: With idle_en at 0, baud ticks never raise ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_strobe | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 1 | Receive error pending (level) |
| rd_strobe | input | 1 | Bus read of the receive data |
| en_wr | input | 1 | Write strobe for the FIFO enable |
| en_val | input | 1 | Enable value written by en_wr |
| flush | input | 1 | FIFO reset: empties the FIFO |
| idle_en | input | 1 | Idle detection enable |
| thr_wr | input | 1 | Threshold write strobe |
| thr_wdata | input | 8 | New threshold value |
| baud_tick | input | 1 | One pulse per baud period |
| count | output | 8 | Number of valid bytes stored |
| rd_data | output | 8 | Byte returned by the last read |
| ready | output | 1 | Receive-ready flag |
| overrun | output | 1 | A byte was dropped because the FIFO was full |
| fifo_en | output | 1 | Current FIFO enable state |

## Verification
The idle timeout is the hardest condition to reach from the ports. It needs a count strictly between zero and the threshold, both enables set, and eight ticks in a row with no byte accepted and no byte read. Random traffic with reads and receives about a third of the time almost never produces such a run. Directed sequences therefore park a few bytes below the threshold and feed exact tick counts of seven and eight. They interrupt the window with a read, a receive, or a disable and re-enable, and check that the full window starts over. A long random phase with rare errors, flushes and threshold changes follows, and a bench model checks every cycle of it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  parameter int unsigned RXQ_DW        = 8;
  parameter int unsigned RXQ_DEPTH     = 16;
  parameter int unsigned RXQ_CNT_W     = 8;
  parameter int unsigned RXQ_IDLE_TCKS = 8;
  parameter int unsigned RXQ_THR_RST   = 8;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    cnt_nxt = cnt;
    if (flush)            cnt_nxt = '0;
    else if (push && !pop) cnt_nxt = cnt + 1'b1;
    else if (pop && !push) cnt_nxt = cnt - 1'b1;
  end

  // storage array without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)      rdata <= '0;
    else if (pop) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= wrap_inc(wptr);
      if (pop)  rptr <= wrap_inc(rptr);
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int unsigned TICKS = 8,
  localparam int unsigned TW   = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic restart,
  input  logic tick,
  output logic hit,
  output logic hit_nxt
);
  logic [TW-1:0] tcnt, tcnt_nxt;

  always_comb begin
    tcnt_nxt = tcnt;
    hit_nxt  = hit;
    if (!active || restart) begin
      tcnt_nxt = '0;
      hit_nxt  = 1'b0;
    end else if (tick && !hit) begin
      tcnt_nxt = tcnt + 1'b1;
      if (tcnt_nxt == TW'(TICKS)) hit_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt <= '0;
      hit  <= 1'b0;
    end else begin
      tcnt <= tcnt_nxt;
      hit  <= hit_nxt;
    end
  end
endmodule

// File: rtl/rxq_ready_ctl.sv
module rxq_ready_ctl
  import rxq_pkg::*;
#(
  parameter int unsigned DW         = RXQ_DW,
  parameter int unsigned DEPTH      = RXQ_DEPTH,
  parameter int unsigned CNT_W      = RXQ_CNT_W,
  parameter int unsigned IDLE_TICKS = RXQ_IDLE_TCKS,
  parameter int unsigned THR_RESET  = RXQ_THR_RST,
  localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_strobe,
  input  logic [DW-1:0]    rx_byte,
  input  logic             rx_err,
  input  logic             rd_strobe,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic             flush,
  input  logic             idle_en,
  input  logic             thr_wr,
  input  logic [CNT_W-1:0] thr_wdata,
  input  logic             baud_tick,
  output logic [CNT_W-1:0] count,
  output logic [DW-1:0]    rd_data,
  output logic             ready,
  output logic             overrun,
  output logic             fifo_en
);
  logic [CW-1:0]    cnt_q, cnt_nxt;
  logic [CNT_W-1:0] thr_q, thr_nxt;
  logic             full, empty, push_ok, pop_ok, drop, active, restart;
  logic             hit, hit_nxt, en_nxt;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = rx_strobe && fifo_en && !full && !flush;
  assign drop    = rx_strobe && fifo_en &&  full && !flush;
  assign pop_ok  = rd_strobe && fifo_en && !empty && !flush;
  assign active  = fifo_en && idle_en && !empty && (CNT_W'(cnt_q) < thr_q);
  assign restart = push_ok || pop_ok || flush;
  assign thr_nxt = thr_wr ? thr_wdata : thr_q;
  assign en_nxt  = rx_err ? 1'b0 : (en_wr ? en_val : fifo_en);
  assign count   = CNT_W'(cnt_q);

  rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .push   (push_ok),
    .pop    (pop_ok),
    .wdata  (rx_byte),
    .rdata  (rd_data),
    .cnt    (cnt_q),
    .cnt_nxt(cnt_nxt)
  );

  rxq_idle_timer #(.TICKS(IDLE_TICKS)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .restart(restart),
    .tick   (baud_tick),
    .hit    (hit),
    .hit_nxt(hit_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q   <= CNT_W'(THR_RESET);
      fifo_en <= 1'b0;
      overrun <= 1'b0;
      ready   <= 1'b0;
    end else begin
      thr_q   <= thr_nxt;
      fifo_en <= en_nxt;
      if (flush)     overrun <= 1'b0;
      else if (drop) overrun <= 1'b1;
      ready   <= (CNT_W'(cnt_nxt) >= thr_nxt) || hit_nxt;
    end
  end
endmodule

// File: rtl/rxq_ready_chk.sv
module rxq_ready_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             rx_err,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] thr,
  input logic             ready,
  input logic             overrun,
  input logic             fifo_en
);
  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count == '0 && !ready && !overrun && !fifo_en));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    !flush |=> ({1'b0, count} <= {1'b0, $past(count)} + 1'b1) &&
               ({1'b0, count} + 1'b1 >= {1'b0, $past(count)}));

  p_ready_thr_r3: assert property (@(posedge clk) disable iff (rst)
    (count >= thr) |-> ready);

  p_err_clears_r7: assert property (@(posedge clk) disable iff (rst)
    rx_err |=> !fifo_en);

  p_disabled_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && !flush) |=> $stable(count));

  p_flush_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0 && !overrun));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  p_ovr_full_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(count) == CNT_W'(DEPTH));
endmodule

bind rxq_ready_ctl rxq_ready_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq_chk (
  .clk    (clk),
  .rst    (rst),
  .flush  (flush),
  .rx_err (rx_err),
  .count  (count),
  .thr    (thr_q),
  .ready  (ready),
  .overrun(overrun),
  .fifo_en(fifo_en)
);

// File: tb/test_rxq_ready_ctl.sv
module test_rxq_ready_ctl;
  logic clk = 1'b0;
  logic rst, rx_strobe, rx_err, rd_strobe, en_wr, en_val, flush, idle_en, thr_wr, baud_tick;
  logic [7:0] rx_byte, thr_wdata, count, rd_data;
  logic ready, overrun, fifo_en;

  always #2 clk = ~clk;

  rxq_ready_ctl i_rxq_ready_ctl (
    .clk(clk), .rst(rst), .rx_strobe(rx_strobe), .rx_byte(rx_byte), .rx_err(rx_err),
    .rd_strobe(rd_strobe), .en_wr(en_wr), .en_val(en_val), .flush(flush),
    .idle_en(idle_en), .thr_wr(thr_wr), .thr_wdata(thr_wdata), .baud_tick(baud_tick),
    .count(count), .rd_data(rd_data), .ready(ready), .overrun(overrun), .fifo_en(fifo_en)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model
  byte unsigned mq[$];
  int m_thr, m_itk;
  bit m_en, m_ovr, m_hit, m_ready, m_rdv;
  byte unsigned m_rd;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    mq.delete(); m_thr = 8; m_itk = 0;
    m_en = 0; m_ovr = 0; m_hit = 0; m_ready = 0; m_rdv = 0;
  endfunction

  function automatic void model_step();
    bit push_ok, pop_ok, drop, act;
    push_ok = rx_strobe && m_en && mq.size() < 16 && !flush;
    drop    = rx_strobe && m_en && mq.size() == 16 && !flush;
    pop_ok  = rd_strobe && m_en && mq.size() > 0 && !flush;
    act     = m_en && idle_en && mq.size() > 0 && mq.size() < m_thr;
    m_rdv   = pop_ok;
    if (flush) begin
      mq.delete(); m_ovr = 0;
    end else begin
      if (pop_ok) m_rd = mq.pop_front();
      if (push_ok) mq.push_back(rx_byte);
      if (drop) m_ovr = 1;
    end
    if (!act || push_ok || pop_ok || flush) begin
      m_itk = 0; m_hit = 0;
    end else if (baud_tick && !m_hit) begin
      m_itk++;
      if (m_itk == 8) m_hit = 1;
    end
    if (thr_wr) m_thr = thr_wdata;
    m_en = rx_err ? 1'b0 : (en_wr ? en_val : m_en);
    m_ready = (mq.size() >= m_thr) || m_hit;
  endfunction

  task automatic clear_in();
    rx_strobe = 0; rx_err = 0; rd_strobe = 0; en_wr = 0; en_val = 0;
    flush = 0; thr_wr = 0; baud_tick = 0; rx_byte = 0; thr_wdata = 0;
  endtask

  // inputs are set at a falling edge; one rising edge applies them; compare at the next falling edge
  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R2 count", count, mq.size());
    chk("R3 ready", ready, m_ready);
    chk("R10 overrun", overrun, m_ovr);
    chk("R7 enable", fifo_en, m_en);
    if (m_rdv) chk("R2 rd_data", rd_data, m_rd);
    clear_in();
  endtask

  task automatic push(input byte unsigned b);
    rx_strobe = 1; rx_byte = b; step();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin baud_tick = 1; step(); end
  endtask

  task automatic set_en(input bit v);
    en_wr = 1; en_val = v; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    clear_in(); idle_en = 0; rst = 1;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 ready", ready, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 enable", fifo_en, 0);

    set_en(1);
    push(8'hA1); push(8'hA2); push(8'hA3);
    ticks(10);
    chk("R12 no idle ready", ready, 0);

    idle_en = 1;
    ticks(7);
    chk("R4 before 8th tick", ready, 0);
    ticks(1);
    chk("R4 after 8th tick", ready, 1);

    rd_strobe = 1; step();
    chk("R11 ready drops after read", ready, 0);
    chk("R2 first byte", rd_data, 8'hA1);
    ticks(7);
    chk("R5 read restarts window", ready, 0);
    ticks(1);
    chk("R5 timeout after read", ready, 1);

    push(8'hB1);
    ticks(7);
    chk("R5 receive restarts window", ready, 0);

    en_wr = 1; en_val = 0; baud_tick = 1; step();
    ticks(3);
    chk("R6 disabled no ready", ready, 0);
    set_en(1);
    ticks(7);
    chk("R6 re-enable restarts", ready, 0);
    ticks(1);
    chk("R6 timeout after re-enable", ready, 1);

    set_en(0);
    push(8'hEE);
    rd_strobe = 1; step();
    chk("R8 count held while disabled", count, 3);

    rx_err = 1; en_wr = 1; en_val = 1; step();
    chk("R7 error clears enable", fifo_en, 0);
    rx_err = 1; en_wr = 1; en_val = 1; step();
    chk("R7 enable blocked", fifo_en, 0);
    set_en(1);
    chk("R7 enable after error", fifo_en, 1);

    for (int i = 0; i < 20; i++) push(byte'(8'h40 + i));
    chk("R10 count saturates", count, 16);
    chk("R10 overrun set", overrun, 1);

    flush = 1; step();
    chk("R9 count cleared", count, 0);
    chk("R9 overrun cleared", overrun, 0);
    chk("R9 ready cleared", ready, 0);

    thr_wr = 1; thr_wdata = 8'd3; step();
    push(8'h11); push(8'h22);
    chk("R3 below threshold", ready, 0);
    push(8'h33);
    chk("R3 at threshold", ready, 1);
    rd_strobe = 1; step();
    chk("R11 below threshold", ready, 0);
    chk("R2 order", rd_data, 8'h11);

    for (int i = 0; i < 4000; i++) begin
      rx_strobe = ($urandom_range(2) == 0);
      rx_byte   = 8'($urandom());
      rd_strobe = ($urandom_range(2) == 0);
      baud_tick = ($urandom_range(1) == 0);
      rx_err    = ($urandom_range(63) == 0);
      en_wr     = ($urandom_range(15) == 0);
      en_val    = ($urandom_range(7) != 0);
      flush     = ($urandom_range(127) == 0);
      thr_wr    = ($urandom_range(63) == 0);
      thr_wdata = 8'($urandom_range(20, 1));
      if ($urandom_range(99) == 0) idle_en = ~idle_en;
      step();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule